// File: doc/BRIEF.md
# Interleaved memory block-refill controller

This block serves one cache-line refill at a time from a lower-level DRAM. The DRAM is modelled inside the block, and its organisation is fixed when the block is built. Three organisations are available:

- **Narrow:** one word per access.
- **Wide:** a bus several words wide, with a multiplexer toward the cache.
- **Interleaved:** four one-word banks, selected by the low bits of the word address.

The controller spends one cycle sending the address. It then waits out a fixed access latency of 15 cycles by default and hands the block to the cache in beats. It measures how many cycles the whole refill took.

The cache raises a request carrying a block address while the controller is idle. The cache then receives a strobe with every beat, giving the index of the first word in the beat and the beat data. The last beat is flagged as done, and at that moment the measured miss penalty is on its output.

In the interleaved organisation all banks begin their access together, and only the word transfers are serialised. Its penalty is therefore 1 + 15 + 4 cycles, against 1 + 4×(15 + 1) for the narrow organisation.

Top module: `refill_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `beat_valid` is 0, `fill_done` is 0 and `penalty` is 0.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1. A request raised while busy starts no further refill, does not change the block being delivered and does not change the measured penalty.
- R3: In the cycle after a request is taken (the address cycle) there is no beat. With `ACC_CYCLES` = 15 the first beat arrives in cycle 17, counting the address cycle as cycle 1.
- R4: In the narrow organisation each beat carries one word. Before every beat there is a separate 15-cycle access, so the beats fall in cycles 17, 33, 49 and 65.
- R5: In the wide organisation each beat carries `BUS_WORDS` words. Beat k (counting from 0) falls in cycle 1 + (k+1)×16. A 2-word bus therefore gives cycles 17 and 33, and a 4-word bus gives cycle 17.
- R6: In the interleaved organisation there is a single 15-cycle access shared by all banks. Word k of the block is delivered in cycle 17 + k, so the words arrive in cycles 17 to 20.
- R7: Lane j of `beat_data`, held in bits [j×DATA_W +: DATA_W], carries word `beat_idx` + j of the block. That word sits at word address blk×`BLOCK_WORDS` + `beat_idx` + j. The word at word address a holds (a × 0x9E3779B1) XOR 0x5A5A5A5A, taken modulo 2^32. In the interleaved organisation, word w of the block comes from bank w (the low word-address bits).
- R8: `fill_done` is 1 for exactly one cycle per refill, in the cycle of the last beat, and never without `beat_valid`.
- R9: While `fill_done` is 1, `penalty` equals the number of cycles from the address cycle to the done cycle inclusive: 65 (narrow), 33 (2-wide), 17 (4-wide) or 20 (interleaved). The value then holds until the next request is taken.
- R10: After the done cycle, `req_ready` is 1 in the next cycle. If `req_valid` is held high, a new request is taken there and pays the full penalty again. The two done pulses are therefore penalty + 1 cycles apart.
- R11: `beat_idx` is the block index of the first word in the beat. It rises from 0 in steps of the beat width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the DRAM contents |
| req_valid | input | 1 | Refill request |
| req_blk | input | BLK_W | Block address of the request |
| req_ready | output | 1 | Controller idle, a request can be taken |
| beat_valid | output | 1 | A beat of block data is on `beat_data` |
| beat_idx | output | IDX_W | Block index of the first word in the beat |
| beat_data | output | BEAT_WORDS×DATA_W | Beat words, lane j in bits [j×DATA_W +: DATA_W] |
| fill_done | output | 1 | Last beat of the refill |
| penalty | output | CNT_W | Measured refill cycles, valid with `fill_done` and held afterwards |

## Verification
Two events can fall in the same cycle. A request may be raised in the cycle where the last beat and the done pulse appear, and a request may be raised while a refill is still running. The bench provokes the first case by holding `req_valid` high across the end of a refill. It judges the outcome by the exact gap between the two done pulses and by the second refill's beats arriving on the full schedule. The bench provokes the second case by pulsing a request with another block address in mid-refill. It then requires that the beats still carry the first block, that the penalty stays at its organisation's value, and that no extra refill follows.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ORG_NARROW      = 2'd0,
        ORG_WIDE        = 2'd1,
        ORG_INTERLEAVED = 2'd2
    } mem_org_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,
        PH_ACCESS = 2'd2,
        PH_XFER   = 2'd3
    } phase_e;

    localparam logic [31:0] FILL_MULT = 32'h9E37_79B1;
    localparam logic [31:0] FILL_MASK = 32'h5A5A_5A5A;

    // words moved to the cache per beat
    function automatic int beat_words(mem_org_e org, int bus_words);
        return (org == ORG_WIDE) ? bus_words : 1;
    endfunction

    // independent DRAM banks that can run an access at the same time
    function automatic int bank_count(mem_org_e org, int block_words);
        return (org == ORG_INTERLEAVED) ? block_words : 1;
    endfunction

    // penalty of one refill in cycles: address + accesses + transfers
    function automatic int refill_cycles(mem_org_e org, int block_words,
                                         int bus_words, int acc);
        int beats;
        beats = block_words / beat_words(org, bus_words);
        if (org == ORG_INTERLEAVED)
            return 1 + acc + block_words;
        return 1 + beats * (acc + 1);
    endfunction

    // DRAM contents loaded at reset
    function automatic logic [31:0] fill_pattern(logic [31:0] waddr);
        return (waddr * FILL_MULT) ^ FILL_MASK;
    endfunction

endpackage

// File: rtl/refill_store.sv
module refill_store import refill_pkg::*; #(
    parameter mem_org_e ORG         = ORG_NARROW,
    parameter int       BLOCK_WORDS = 4,
    parameter int       BUS_WORDS   = 4,
    parameter int       MEM_WORDS   = 64,
    parameter int       DATA_W      = 32,
    localparam int      NB          = bank_count(ORG, BLOCK_WORDS),
    localparam int      RW          = beat_words(ORG, BUS_WORDS),
    localparam int      ROWS        = MEM_WORDS / (NB * RW),
    localparam int      ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture,
    input  logic [ROW_W-1:0]         row_addr,
    output logic [NB*RW*DATA_W-1:0]  held
);

    // Each bank stores rows of RW words; word address = (row*RW + lane)*NB + bank,
    // so with several banks consecutive words fall in consecutive banks.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [RW*DATA_W-1:0] cells [ROWS];
        logic [RW*DATA_W-1:0] sense_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int l = 0; l < RW; l++) begin
                        cells[r][l*DATA_W +: DATA_W] <=
                            DATA_W'(fill_pattern(32'((r * RW + l) * NB + b)));
                    end
                end
                sense_q <= '0;
            end else if (capture) begin
                // access completes: row lands in the bank output latch
                sense_q <= cells[row_addr];
            end
        end

        assign held[b*RW*DATA_W +: RW*DATA_W] = sense_q;
    end

endmodule

// File: rtl/refill_seq.sv
module refill_seq import refill_pkg::*; #(
    parameter mem_org_e ORG         = ORG_NARROW,
    parameter int       BLOCK_WORDS = 4,
    parameter int       ACC_CYCLES  = 15,
    parameter int       NB          = 1,
    parameter int       RW          = 1,
    parameter int       BLK_W       = 4,
    parameter int       ROW_W       = 4,
    localparam int      NBEATS      = BLOCK_WORDS / RW,
    localparam int      BEAT_W      = (NBEATS > 1) ? $clog2(NBEATS) : 1,
    localparam int      WAIT_W      = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              req_ready,
    output logic              accept,
    output logic              capture,
    output logic [ROW_W-1:0]  row_addr,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_num,
    output logic              fill_done
);

    phase_e             phase;
    logic [WAIT_W-1:0]  wait_cnt;
    logic [BEAT_W-1:0]  beat;
    logic [BLK_W-1:0]   blk_q;
    logic               last_beat;

    assign last_beat  = (int'(beat) == NBEATS - 1);
    assign req_ready  = (phase == PH_IDLE);
    assign accept     = req_ready && req_valid;
    assign capture    = (phase == PH_ACCESS) && (wait_cnt == '0);
    assign beat_valid = (phase == PH_XFER);
    assign fill_done  = beat_valid && last_beat;
    assign beat_num   = beat;

    // row holding the next word(s) to fetch
    always_comb begin
        row_addr = ROW_W'((int'(blk_q) * BLOCK_WORDS + int'(beat) * RW) / (NB * RW));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            wait_cnt <= '0;
            beat     <= '0;
            blk_q    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        blk_q <= req_blk;
                        beat  <= '0;
                        phase <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    wait_cnt <= WAIT_W'(ACC_CYCLES - 1);
                    phase    <= PH_ACCESS;
                end
                PH_ACCESS: begin
                    if (wait_cnt == '0) phase <= PH_XFER;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                PH_XFER: begin
                    if (last_beat) begin
                        phase <= PH_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                        if (ORG != ORG_INTERLEAVED) begin
                            // one bank: every beat needs its own access
                            wait_cnt <= WAIT_W'(ACC_CYCLES - 1);
                            phase    <= PH_ACCESS;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/refill_timer.sv
module refill_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    // cycle k of a refill (address cycle = 1) shows count == k
    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (start) count <= CNT_W'(1);
        else if (run)   count <= count + 1'b1;
    end

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl import refill_pkg::*; #(
    parameter mem_org_e ORG         = ORG_NARROW,
    parameter int       BLOCK_WORDS = 4,
    parameter int       BUS_WORDS   = 4,
    parameter int       ACC_CYCLES  = 15,
    parameter int       MEM_WORDS   = 64,
    parameter int       DATA_W      = 32,
    localparam int      BEAT_WORDS  = beat_words(ORG, BUS_WORDS),
    localparam int      BLK_W       = $clog2(MEM_WORDS / BLOCK_WORDS),
    localparam int      IDX_W       = $clog2(BLOCK_WORDS),
    localparam int      CNT_W       = $clog2(BLOCK_WORDS * (ACC_CYCLES + 1) + 2)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [BLK_W-1:0]             req_blk,
    output logic                         req_ready,
    output logic                         beat_valid,
    output logic [IDX_W-1:0]             beat_idx,
    output logic [BEAT_WORDS*DATA_W-1:0] beat_data,
    output logic                         fill_done,
    output logic [CNT_W-1:0]             penalty
);

    localparam int NB      = bank_count(ORG, BLOCK_WORDS);
    localparam int NBEATS  = BLOCK_WORDS / BEAT_WORDS;
    localparam int BEAT_W  = (NBEATS > 1) ? $clog2(NBEATS) : 1;
    localparam int ROWS    = MEM_WORDS / (NB * BEAT_WORDS);
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int EXP_PEN = refill_cycles(ORG, BLOCK_WORDS, BUS_WORDS, ACC_CYCLES);

    logic                             accept;
    logic                             capture;
    logic [ROW_W-1:0]                 row_addr;
    logic [BEAT_W-1:0]                beat_num;
    logic [NB*BEAT_WORDS*DATA_W-1:0]  held;

    refill_seq #(
        .ORG(ORG), .BLOCK_WORDS(BLOCK_WORDS), .ACC_CYCLES(ACC_CYCLES),
        .NB(NB), .RW(BEAT_WORDS), .BLK_W(BLK_W), .ROW_W(ROW_W)
    ) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
        .req_ready(req_ready), .accept(accept), .capture(capture),
        .row_addr(row_addr), .beat_valid(beat_valid), .beat_num(beat_num),
        .fill_done(fill_done)
    );

    refill_store #(
        .ORG(ORG), .BLOCK_WORDS(BLOCK_WORDS), .BUS_WORDS(BUS_WORDS),
        .MEM_WORDS(MEM_WORDS), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst), .capture(capture), .row_addr(row_addr), .held(held)
    );

    refill_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(accept),
        .run(!req_ready && !fill_done), .count(penalty)
    );

    // R7: interleaved picks the bank by the low word-address bits (= word index)
    if (ORG == ORG_INTERLEAVED) begin : g_bank_mux
        assign beat_data = held[int'(beat_num)*DATA_W +: DATA_W];
    end else begin : g_row_pass
        assign beat_data = held;
    end

    assign beat_idx = IDX_W'(int'(beat_num) * BEAT_WORDS);

endmodule

module refill_chk #(
    parameter int CNT_W   = 7,
    parameter int EXP_PEN = 65
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             beat_valid,
    input logic             fill_done,
    input logic [CNT_W-1:0] penalty
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !beat_valid && !fill_done && penalty == '0));

    p_busy_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !fill_done) |=> !req_ready);

    p_addr_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && !beat_valid));

    p_done_with_beat_r8: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> beat_valid);

    p_penalty_value_r9: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (penalty == CNT_W'(EXP_PEN)));

    p_penalty_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> $stable(penalty));

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> req_ready);

endmodule

bind refill_ctrl refill_chk #(.CNT_W(CNT_W), .EXP_PEN(EXP_PEN)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .beat_valid(beat_valid), .fill_done(fill_done), .penalty(penalty)
);

// File: tb/sim_refill_ctrl.sv
module sim_refill_ctrl;
    import refill_pkg::*;

    localparam int NI  = 4;
    localparam int ACC = 15;
    localparam int BW  = 4;
    localparam int LANES [NI] = '{1, 2, 4, 1};
    localparam int PEN   [NI] = '{65, 33, 17, 20};

    typedef struct {
        int           at;
        int           idx;
        logic [127:0] data;
        bit           last;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        rv  [NI];
    logic [3:0]  rb  [NI];
    logic        rdy [NI];
    logic        bv  [NI];
    logic        dn  [NI];
    logic [1:0]  bi  [NI];
    logic [6:0]  pn  [NI];
    logic [31:0]  d0, d3;
    logic [63:0]  d1;
    logic [127:0] d2;

    int   n_chk = 0, n_bad = 0, cyc_abs = 0;
    bit   finished = 0;
    exp_t sbq [NI][$];
    int   since [NI], n_acc [NI], done_at [NI], done_prev [NI];
    bit   live [NI];

    refill_ctrl #(.ORG(ORG_NARROW), .ACC_CYCLES(ACC)) u0 (
        .clk(clk), .rst(rst), .req_valid(rv[0]), .req_blk(rb[0]), .req_ready(rdy[0]),
        .beat_valid(bv[0]), .beat_idx(bi[0]), .beat_data(d0), .fill_done(dn[0]), .penalty(pn[0]));
    refill_ctrl #(.ORG(ORG_WIDE), .BUS_WORDS(2), .ACC_CYCLES(ACC)) u1 (
        .clk(clk), .rst(rst), .req_valid(rv[1]), .req_blk(rb[1]), .req_ready(rdy[1]),
        .beat_valid(bv[1]), .beat_idx(bi[1]), .beat_data(d1), .fill_done(dn[1]), .penalty(pn[1]));
    refill_ctrl #(.ORG(ORG_WIDE), .BUS_WORDS(4), .ACC_CYCLES(ACC)) u2 (
        .clk(clk), .rst(rst), .req_valid(rv[2]), .req_blk(rb[2]), .req_ready(rdy[2]),
        .beat_valid(bv[2]), .beat_idx(bi[2]), .beat_data(d2), .fill_done(dn[2]), .penalty(pn[2]));
    refill_ctrl #(.ORG(ORG_INTERLEAVED), .ACC_CYCLES(ACC)) u3 (
        .clk(clk), .rst(rst), .req_valid(rv[3]), .req_blk(rb[3]), .req_ready(rdy[3]),
        .beat_valid(bv[3]), .beat_idx(bi[3]), .beat_data(d3), .fill_done(dn[3]), .penalty(pn[3]));

    function automatic logic [31:0] word_at(int a);
        logic [31:0] x;
        x = 32'(a);
        return (x * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver side: push the expected beats of one refill
    task automatic expect_refill(input int i, input int blk);
        int nb;
        nb = BW / LANES[i];
        for (int k = 0; k < nb; k++) begin
            exp_t e;
            e.at   = (i == 3) ? (2 + ACC + k) : (1 + (k + 1) * (ACC + 1));
            e.idx  = k * LANES[i];
            e.data = '0;
            for (int j = 0; j < LANES[i]; j++)
                e.data[j*32 +: 32] = word_at(blk * BW + k * LANES[i] + j);
            e.last = (k == nb - 1);
            sbq[i].push_back(e);
        end
    endtask

    task automatic start_all(input int b0, input int b1, input int b2, input int b3);
        expect_refill(0, b0); expect_refill(1, b1);
        expect_refill(2, b2); expect_refill(3, b3);
        @(posedge clk); #2;
        rb[0] = 4'(b0); rb[1] = 4'(b1); rb[2] = 4'(b2); rb[3] = 4'(b3);
        for (int i = 0; i < NI; i++) rv[i] = 1'b1;
        @(posedge clk); #2;
        for (int i = 0; i < NI; i++) rv[i] = 1'b0;
    endtask

    // monitor side: pop and compare each beat as it appears
    task automatic observe(input int i, input logic rq, input logic r, input logic b,
                           input logic d, input logic [1:0] idx,
                           input logic [127:0] data, input logic [6:0] p);
        string tm;
        tm = (i == 0) ? "R4" : (i == 3) ? "R6" : "R5";
        if (live[i]) since[i]++;
        if (b === 1'b1) begin
            if (sbq[i].size() == 0) begin
                chk(0, "R2", $sformatf("u%0d unexpected beat", i), 128'(idx), 128'(0));
            end else begin
                exp_t e;
                e = sbq[i].pop_front();
                chk(since[i] == e.at, (e.idx == 0) ? "R3" : tm,
                    $sformatf("u%0d beat cycle", i), 128'(since[i]), 128'(e.at));
                chk(int'(idx) == e.idx, "R11", $sformatf("u%0d beat_idx", i),
                    128'(idx), 128'(e.idx));
                chk(data === e.data, "R7", $sformatf("u%0d beat_data", i), data, e.data);
                chk(d === e.last, "R8", $sformatf("u%0d done flag", i),
                    128'(d), 128'(e.last));
            end
        end else if (d === 1'b1) begin
            chk(0, "R8", $sformatf("u%0d done without beat", i), 128'(d), 128'(0));
        end
        if (d === 1'b1) begin
            chk(int'(p) == PEN[i], "R9", $sformatf("u%0d penalty", i), 128'(p), 128'(PEN[i]));
            live[i]      = 0;
            done_prev[i] = done_at[i];
            done_at[i]   = cyc_abs;
        end
        if (rq === 1'b1 && r === 1'b1 && rst === 1'b0) begin
            live[i]  = 1;
            since[i] = 0;
            n_acc[i]++;
        end
    endtask

    always @(posedge clk) cyc_abs++;
    always @(negedge clk) observe(0, rv[0], rdy[0], bv[0], dn[0], bi[0], 128'(d0), pn[0]);
    always @(negedge clk) observe(1, rv[1], rdy[1], bv[1], dn[1], bi[1], 128'(d1), pn[1]);
    always @(negedge clk) observe(2, rv[2], rdy[2], bv[2], dn[2], bi[2], d2, pn[2]);
    always @(negedge clk) observe(3, rv[3], rdy[3], bv[3], dn[3], bi[3], 128'(d3), pn[3]);

    initial begin
        int base;
        for (int i = 0; i < NI; i++) begin
            rv[i] = 1'b0; rb[i] = '0; since[i] = 0; n_acc[i] = 0;
            done_at[i] = 0; done_prev[i] = 0; live[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk(rdy[i] === 1'b1 && bv[i] === 1'b0 && dn[i] === 1'b0, "R1",
                $sformatf("u%0d reset ready/valid/done", i),
                128'({rdy[i], bv[i], dn[i]}), 128'(3'b100));
            chk(pn[i] === 7'd0, "R1", $sformatf("u%0d reset penalty", i), 128'(pn[i]), 128'(0));
        end
        @(posedge clk); #2; rst = 1'b0;

        // first pattern, then the two end blocks of the address range
        start_all(2, 5, 7, 11);
        repeat (80) @(posedge clk);
        start_all(0, 15, 0, 15);
        repeat (80) @(posedge clk);

        // R9: penalty holds while idle
        @(negedge clk);
        for (int i = 0; i < NI; i++)
            chk(int'(pn[i]) == PEN[i], "R9", $sformatf("u%0d held penalty", i),
                128'(pn[i]), 128'(PEN[i]));

        // R2: a request raised mid-refill is ignored
        base = n_acc[0];
        expect_refill(0, 3);
        @(posedge clk); #2; rb[0] = 4'd3; rv[0] = 1'b1;
        @(posedge clk); #2; rv[0] = 1'b0;
        repeat (25) @(posedge clk);
        #2; rb[0] = 4'd9; rv[0] = 1'b1;
        repeat (10) @(posedge clk);
        #2; rv[0] = 1'b0;
        repeat (80) @(posedge clk);
        @(negedge clk);
        chk(n_acc[0] == base + 1, "R2", "u0 refills taken", 128'(n_acc[0] - base), 128'(1));
        chk(sbq[0].size() == 0, "R2", "u0 beats left", 128'(sbq[0].size()), 128'(0));
        chk(int'(pn[0]) == PEN[0], "R2", "u0 penalty after ignored request",
            128'(pn[0]), 128'(PEN[0]));

        // R10: request held high across the done cycle, on u3 and u0
        for (int i = 0; i < NI; i = i + 3) begin
            base = n_acc[i];
            expect_refill(i, 6);
            expect_refill(i, 6);
            @(posedge clk); #2; rb[i] = 4'd6; rv[i] = 1'b1;
            wait (n_acc[i] == base + 2);
            @(posedge clk); #2; rv[i] = 1'b0;
            repeat (80) @(posedge clk);
            @(negedge clk);
            chk(n_acc[i] == base + 2, "R10", $sformatf("u%0d back-to-back refills", i),
                128'(n_acc[i] - base), 128'(2));
            chk(done_at[i] - done_prev[i] == PEN[i] + 1, "R10",
                $sformatf("u%0d done spacing", i),
                128'(done_at[i] - done_prev[i]), 128'(PEN[i] + 1));
        end

        for (int i = 0; i < NI; i++)
            chk(sbq[i].size() == 0, "R8", $sformatf("u%0d missing beats", i),
                128'(sbq[i].size()), 128'(0));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule